// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block holds the pending state of inter-processor software interrupts for a distributor serving up to eight CPUs and sixteen software interrupt IDs. For every target CPU and every ID it keeps a mask with one bit per requesting CPU. A pending flag marks that at least one request for that ID is waiting at that target. A CPU raises a software interrupt by writing a generate word. The word names the ID, a target list and a filter mode that picks the targets. The filter can use the written list, select every online CPU except the writer, or select only the writer.

Two byte-lane windows let a CPU inspect and edit the masks aimed at itself. A write to the set window ORs each byte into a mask. A write to the clear window removes the bits that are 1 in each byte. Both windows read back the same masks. A one-cycle update pulse follows any bus write that changed a mask. A CPU interface retires requests through a drain port. Each drain removes the lowest-numbered source from one mask and returns that source number. When the mask empties, the pending flag drops.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every mask and every pending flag is zero, `drain_valid_o` and `state_upd_o` are low and the windows read zero.
- R2: A generate write (`bus_sel`=0) takes the ID from bits [3:0], the target list from bits [23:16] (bit 16 = CPU 0) and the filter from bits [25:24]. Filter 0 uses the list, and an all-zero list generates nothing.
- R3: Filter 1 selects every online CPU except the writer (`bus_cpu`). Filter 2 selects only the writer and ignores the list. Filter 3 behaves as filter 0.
- R4: CPUs numbered at or above `online_cnt` are never selected.
- R5: For each selected target T and ID I, bit `bus_cpu` of mask [T][I] is set one cycle after the write, and `pending_o[T*16+I]` goes high. Pending flags change only on a bus write or a drain.
- R6: The generate register and the unused region (`bus_sel`=3) read as zero. Writes to the unused region change nothing.
- R7: With `bus_sel`=1 (set) or 2 (clear), word `bus_word`=w covers IDs 4w to 4w+3. Byte k (bits 8k+7:8k) is the mask of ID 4w+k aimed at CPU `bus_cpu`, and bit j of that byte is source CPU j. Both windows read these masks combinationally.
- R8: A set-window write ORs each byte into its mask, and a non-empty result sets the pending flag. A clear-window write clears the 1 bits, and an empty result clears the pending flag.
- R9: `state_upd_o` is high for exactly the cycle after a bus write that changed at least one mask bit, and low otherwise.
- R10: A drain request for (`drain_cpu`, `drain_id`) with a non-empty mask removes its lowest set bit. In the next cycle `drain_valid_o` is high and `drain_src_o` holds that bit's number. An empty mask gives `drain_valid_o` low.
- R11: A drain that empties a mask clears that pending flag. A drain that leaves bits set keeps it.
- R12: A drain request in a cycle with a bus write is not served: `drain_valid_o` stays low and the mask is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online_cnt | input | 4 | Number of CPUs online |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Region: 0 generate, 1 set window, 2 clear window, 3 unused |
| bus_word | input | 2 | Word index inside a window |
| bus_cpu | input | 3 | Number of the accessing CPU |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| state_upd_o | output | 1 | One-cycle pulse after a write that changed a mask |
| pending_o | output | 128 | Pending flags, bit T*16+I |
| drain_req | input | 1 | Drain request |
| drain_cpu | input | 3 | Target CPU whose mask is drained |
| drain_id | input | 4 | Interrupt ID drained |
| drain_valid_o | output | 1 | A source was retired last cycle |
| drain_src_o | output | 3 | Number of the retired source CPU |

## Verification
The bench builds the block with its defaults of eight CPUs and sixteen IDs. This makes every byte lane and all four window words reachable, including the top ID 15 and source bit 7. The bench drives `online_cnt` at runtime rather than through a parameter. It first runs with all eight CPUs online, then drops to four. At four CPUs, targets above the online count must be filtered out of both the written list and the all-but-writer mode.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    typedef enum logic [1:0] {
        REG_GEN  = 2'd0,
        REG_SETP = 2'd1,
        REG_CLRP = 2'd2,
        REG_NONE = 2'd3
    } sgi_reg_e;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;

    localparam int LIST_LSB = 16;
    localparam int MODE_LSB = 24;
    localparam int IDS_PER_WORD = 4;
endpackage

// File: rtl/sgi_gen_decode.sv
module sgi_gen_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_IDS  = 16,
    localparam int CPU_W = $clog2(NUM_CPUS),
    localparam int ID_W  = $clog2(NUM_IDS),
    localparam int ONL_W = $clog2(NUM_CPUS + 1)
) (
    input  logic [31:0]         wdata,
    input  logic [CPU_W-1:0]    writer,
    input  logic [ONL_W-1:0]    online,
    output logic [ID_W-1:0]     id,
    output logic [NUM_CPUS-1:0] targets
);
    logic [NUM_CPUS-1:0] online_mask;
    logic [NUM_CPUS-1:0] self_mask;
    logic [NUM_CPUS-1:0] raw;
    sgi_filter_e         mode;
    logic                unused_wdata;

    assign unused_wdata = ^wdata;

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_online
        assign online_mask[g] = (g < int'(online));
    end

    assign id   = wdata[ID_W-1:0];
    assign mode = sgi_filter_e'(wdata[MODE_LSB +: 2]);

    always_comb begin
        self_mask         = '0;
        self_mask[writer] = 1'b1;
        case (mode)
            FLT_OTHERS: raw = online_mask & ~self_mask;
            FLT_SELF:   raw = self_mask;
            default:    raw = wdata[LIST_LSB +: NUM_CPUS];
        endcase
        targets = raw & online_mask;
    end
endmodule

// File: rtl/sgi_lowbit.sv
module sgi_lowbit #(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_IDS  = 16,
    localparam int CPU_W  = $clog2(NUM_CPUS),
    localparam int ID_W   = $clog2(NUM_IDS),
    localparam int ONL_W  = $clog2(NUM_CPUS + 1),
    localparam int WORDS  = NUM_IDS / IDS_PER_WORD,
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ONL_W-1:0]            online_cnt,
    input  logic                        bus_wr,
    input  logic [1:0]                  bus_sel,
    input  logic [WORD_W-1:0]           bus_word,
    input  logic [CPU_W-1:0]            bus_cpu,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        state_upd_o,
    output logic [NUM_CPUS*NUM_IDS-1:0] pending_o,
    input  logic                        drain_req,
    input  logic [CPU_W-1:0]            drain_cpu,
    input  logic [ID_W-1:0]             drain_id,
    output logic                        drain_valid_o,
    output logic [CPU_W-1:0]            drain_src_o
);
    typedef struct packed {
        logic [NUM_CPUS-1:0][NUM_IDS-1:0][NUM_CPUS-1:0] mask;
        logic [NUM_CPUS-1:0][NUM_IDS-1:0]               pend;
        logic                                           upd;
        logic                                           dvalid;
        logic [CPU_W-1:0]                               dsrc;
    } st_t;

    st_t st_d, st_q;

    sgi_reg_e            region;
    logic [ID_W-1:0]     gen_id;
    logic [NUM_CPUS-1:0] gen_targets;
    logic [NUM_CPUS-1:0] drain_mask;
    logic                lb_found;
    logic [CPU_W-1:0]    lb_idx;

    assign region     = sgi_reg_e'(bus_sel);
    assign drain_mask = st_q.mask[drain_cpu][drain_id];

    sgi_gen_decode #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS)) u_decode (
        .wdata   (bus_wdata),
        .writer  (bus_cpu),
        .online  (online_cnt),
        .id      (gen_id),
        .targets (gen_targets)
    );

    sgi_lowbit #(.W(NUM_CPUS)) u_lowbit (
        .vec   (drain_mask),
        .found (lb_found),
        .idx   (lb_idx)
    );

    always_comb begin
        logic                changed;
        logic [NUM_CPUS-1:0] old_m;
        logic [NUM_CPUS-1:0] new_m;
        logic [NUM_CPUS-1:0] lane;
        logic [NUM_CPUS-1:0] rest;
        logic [ID_W-1:0]     sid;
        int                  idx;

        st_d        = st_q;
        st_d.upd    = 1'b0;
        st_d.dvalid = 1'b0;
        st_d.dsrc   = '0;
        changed     = 1'b0;
        bus_rdata   = '0;
        rest        = drain_mask;
        rest[lb_idx] = 1'b0;

        for (int k = 0; k < IDS_PER_WORD; k++) begin
            idx = int'(bus_word) * IDS_PER_WORD + k;
            sid = ID_W'(idx);
            if ((region == REG_SETP || region == REG_CLRP) && idx < NUM_IDS) begin
                bus_rdata[8*k +: NUM_CPUS] = st_q.mask[bus_cpu][sid];
            end
        end

        if (bus_wr) begin
            case (region)
                REG_GEN: begin
                    for (int t = 0; t < NUM_CPUS; t++) begin
                        if (gen_targets[t]) begin
                            if (!st_q.mask[CPU_W'(t)][gen_id][bus_cpu]) changed = 1'b1;
                            st_d.mask[CPU_W'(t)][gen_id][bus_cpu] = 1'b1;
                            st_d.pend[CPU_W'(t)][gen_id]          = 1'b1;
                        end
                    end
                end
                REG_SETP, REG_CLRP: begin
                    for (int k = 0; k < IDS_PER_WORD; k++) begin
                        idx = int'(bus_word) * IDS_PER_WORD + k;
                        sid = ID_W'(idx);
                        if (idx < NUM_IDS) begin
                            old_m = st_q.mask[bus_cpu][sid];
                            lane  = bus_wdata[8*k +: NUM_CPUS];
                            new_m = (region == REG_SETP) ? (old_m | lane) : (old_m & ~lane);
                            if (new_m != old_m) changed = 1'b1;
                            st_d.mask[bus_cpu][sid] = new_m;
                            if (region == REG_SETP) begin
                                if (new_m != '0) st_d.pend[bus_cpu][sid] = 1'b1;
                            end else begin
                                if (new_m == '0) st_d.pend[bus_cpu][sid] = 1'b0;
                            end
                        end
                    end
                end
                default: ;
            endcase
            st_d.upd = changed;
        end else if (drain_req && lb_found) begin
            st_d.mask[drain_cpu][drain_id][lb_idx] = 1'b0;
            st_d.dvalid = 1'b1;
            st_d.dsrc   = lb_idx;
            if (rest == '0) st_d.pend[drain_cpu][drain_id] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_upd_o   = st_q.upd;
    assign pending_o     = st_q.pend;
    assign drain_valid_o = st_q.dvalid;
    assign drain_src_o   = st_q.dsrc;

    assert_drain_served_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !bus_wr && (drain_mask != '0)) |=> drain_valid_o);

    assert_drain_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && bus_wr) |=> !drain_valid_o);

    assert_upd_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_upd_o |-> $past(bus_wr));

    assert_pend_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !drain_req) |=> $stable(pending_o));

    assert_valid_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid_o |-> $past(drain_req));
endmodule

// File: tb/sgi_dispatch_bench.sv
`timescale 1ns/1ps
module sgi_dispatch_bench;
    localparam int NC = 8;
    localparam int NI = 16;
    localparam int NV = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   online_cnt = 4'd8;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_sel = 2'd0;
    logic [1:0]   bus_word = 2'd0;
    logic [2:0]   bus_cpu = 3'd0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         state_upd_o;
    logic [127:0] pending_o;
    logic         drain_req = 1'b0;
    logic [2:0]   drain_cpu = 3'd0;
    logic [3:0]   drain_id = 4'd0;
    logic         drain_valid_o;
    logic [2:0]   drain_src_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    sgi_dispatch #(.NUM_CPUS(NC), .NUM_IDS(NI)) u_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt),
        .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_word(bus_word),
        .bus_cpu(bus_cpu), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .state_upd_o(state_upd_o), .pending_o(pending_o),
        .drain_req(drain_req), .drain_cpu(drain_cpu), .drain_id(drain_id),
        .drain_valid_o(drain_valid_o), .drain_src_o(drain_src_o)
    );

    // {wcpu, wsel, wword, wdata, rcpu, rword, expected set-window read}
    localparam logic [75:0] VEC [0:NV-1] = '{
        {3'd0, 2'd0, 2'd0, 32'h0002_0003, 3'd1, 2'd0, 32'h0100_0000},
        {3'd2, 2'd0, 2'd0, 32'h0100_0005, 3'd0, 2'd1, 32'h0000_0400},
        {3'd6, 2'd0, 2'd0, 32'h02FF_0000, 3'd6, 2'd0, 32'h0000_0040},
        {3'd1, 2'd0, 2'd0, 32'h0000_0000, 3'd1, 2'd0, 32'h0100_0000},
        {3'd3, 2'd0, 2'd0, 32'h0301_0003, 3'd0, 2'd0, 32'h0800_0000},
        {3'd0, 2'd1, 2'd3, 32'h8000_0011, 3'd0, 2'd3, 32'h8000_0011},
        {3'd0, 2'd2, 2'd3, 32'hFF00_0001, 3'd0, 2'd3, 32'h0000_0010},
        {3'd0, 2'd2, 2'd1, 32'h0000_0400, 3'd0, 2'd1, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] cpu, input logic [1:0] sel,
                      input logic [1:0] word, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = cpu; bus_sel = sel; bus_word = word; bus_wdata = data;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rdw(input logic [2:0] cpu, input logic [1:0] sel,
                       input logic [1:0] word, output logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b0; bus_cpu = cpu; bus_sel = sel; bus_word = word;
        #1 data = bus_rdata;
    endtask

    task automatic drn(input logic [2:0] cpu, input logic [3:0] id);
        @(negedge clk);
        drain_req = 1'b1; drain_cpu = cpu; drain_id = id;
        @(posedge clk); #1;
        drain_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 pending", {31'd0, |pending_o}, 32'd0);
        chk("R1 drain_valid", {31'd0, drain_valid_o}, 32'd0);
        chk("R1 upd", {31'd0, state_upd_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        rdw(3'd0, 2'd1, 2'd0, rd); chk("R1 window", rd, 32'd0);

        // Vector table: R2 R3 R5 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [75:0] e;
            e = VEC[v];
            wr(e[75:73], e[72:71], e[70:69], e[68:37]);
            rdw(e[36:34], 2'd1, e[33:32], rd);
            chk($sformatf("R2/R3/R7/R8 vec%0d", v), rd, e[31:0]);
        end

        // R5 / R8: pending flags after the table
        chk("R5 p[1][3]", {31'd0, pending_o[1*16+3]}, 32'd1);
        chk("R3 p[0][3]", {31'd0, pending_o[0*16+3]}, 32'd1);
        chk("R3 writer excluded p[2][5]", {31'd0, pending_o[2*16+5]}, 32'd0);
        chk("R3 p[7][5]", {31'd0, pending_o[7*16+5]}, 32'd1);
        chk("R3 self p[6][0]", {31'd0, pending_o[6*16+0]}, 32'd1);
        chk("R2 empty list p[1][0]", {31'd0, pending_o[1*16+0]}, 32'd0);
        chk("R8 set p[0][12]", {31'd0, pending_o[0*16+12]}, 32'd1);
        chk("R8 clear p[0][15]", {31'd0, pending_o[0*16+15]}, 32'd0);
        chk("R8 clear p[0][5]", {31'd0, pending_o[0*16+5]}, 32'd0);
        rdw(3'd0, 2'd2, 2'd3, rd); chk("R7 clear window read", rd, 32'h0000_0010);

        // R6: generate and unused regions read zero, unused writes ignored
        rdw(3'd0, 2'd0, 2'd0, rd); chk("R6 gen read", rd, 32'd0);
        wr(3'd0, 2'd3, 2'd3, 32'hFFFF_FFFF);
        chk("R6 unused write upd", {31'd0, state_upd_o}, 32'd0);
        rdw(3'd0, 2'd3, 2'd3, rd); chk("R6 unused read", rd, 32'd0);
        rdw(3'd0, 2'd1, 2'd3, rd); chk("R6 window intact", rd, 32'h0000_0010);

        // R9: update pulse only on change
        wr(3'd0, 2'd1, 2'd1, 32'h0A00_0000);
        chk("R9 pulse on change", {31'd0, state_upd_o}, 32'd1);
        @(posedge clk); #1;
        chk("R9 pulse one cycle", {31'd0, state_upd_o}, 32'd0);
        wr(3'd0, 2'd1, 2'd1, 32'h0A00_0000);
        chk("R9 no pulse without change", {31'd0, state_upd_o}, 32'd0);
        wr(3'd0, 2'd0, 2'd0, 32'h0002_0003);
        chk("R9 repeat generate no pulse", {31'd0, state_upd_o}, 32'd0);

        // R10 / R11: drain lowest source first
        drn(3'd0, 4'd7);
        chk("R10 valid", {31'd0, drain_valid_o}, 32'd1);
        chk("R10 src 1", {29'd0, drain_src_o}, 32'd1);
        chk("R11 pend kept", {31'd0, pending_o[0*16+7]}, 32'd1);
        drn(3'd0, 4'd7);
        chk("R10 src 3", {29'd0, drain_src_o}, 32'd3);
        chk("R11 pend cleared", {31'd0, pending_o[0*16+7]}, 32'd0);
        drn(3'd0, 4'd7);
        chk("R10 empty no valid", {31'd0, drain_valid_o}, 32'd0);

        // R12: drain blocked by a concurrent bus write
        wr(3'd0, 2'd1, 2'd2, 32'h0000_0001);
        @(negedge clk);
        drain_req = 1'b1; drain_cpu = 3'd0; drain_id = 4'd8;
        bus_wr = 1'b1; bus_sel = 2'd3; bus_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        drain_req = 1'b0; bus_wr = 1'b0;
        chk("R12 no valid", {31'd0, drain_valid_o}, 32'd0);
        rdw(3'd0, 2'd1, 2'd2, rd); chk("R12 mask kept", rd, 32'h0000_0001);

        // R4: only four CPUs online
        online_cnt = 4'd4;
        wr(3'd0, 2'd0, 2'd0, 32'h00F0_0009);
        chk("R4 offline list no upd", {31'd0, state_upd_o}, 32'd0);
        chk("R4 p[4][9]", {31'd0, pending_o[4*16+9]}, 32'd0);
        wr(3'd0, 2'd0, 2'd0, 32'h0100_000A);
        chk("R4 p[1][10]", {31'd0, pending_o[1*16+10]}, 32'd1);
        chk("R4 p[3][10]", {31'd0, pending_o[3*16+10]}, 32'd1);
        chk("R4 p[4][10]", {31'd0, pending_o[4*16+10]}, 32'd0);
        chk("R4 writer p[0][10]", {31'd0, pending_o[0*16+10]}, 32'd0);

        finish_run();
    end
endmodule